// File: doc/BRIEF.md
# Threshold Calibration Sequencer

This block runs the foreground trim of every comparator threshold in a two-stage (coarse plus fine) converter. When a run is requested, it switches the converter from its track-and-hold input to a switched reference source and turns that source on. It then takes the comparators one by one and, for each, points the reference selector at that comparator's own threshold. It enables only that comparator's trim logic and finds its 6-bit capacitor trim code by a binary search driven by the comparator's decision.

All coarse comparators are handled before any fine comparator. The fine references travel through the residue DAC, so the code stored for a fine comparator also absorbs the DAC gain error and the built-in threshold error. Each final code is kept in a register file that drives the trim bus while the converter converts. When the last comparator is done, the block raises done, reconnects the track-and-hold and powers the reference source down. A read port returns any stored code by index.

Top module: `calSequencer`

## Requirements
- R1: After reset, thConnect is 1, refGenOn, calBusy, done and every calEn bit are 0, and every stored trim code and the whole trim bus are 0.
- R2: A start pulse while idle makes calBusy 1, thConnect 0 and refGenOn 1 from the following clock edge, and they stay so for the whole run.
- R3: While busy, calEn is one-hot with bit n set exactly when refSel equals n; while idle, calEn is all zeros.
- R4: refSel begins at 0 and only ever steps up by 1, through the NUM_COARSE coarse entries (fineStage 0) and then the NUM_FINE fine entries (fineStage 1, refSel at least NUM_COARSE).
- R5: The trial code for a comparator starts at the MSB alone (binary 100000). At each decision, a decision of 1 clears the bit under test and a decision of 0 keeps it, and the next lower bit is then set. The stored code is therefore the largest code for which the decision is 0, or 0 if there is none.
- R6: Every trial code stays on the selected comparator's trim slot for settleCycles+1 cycles before its decision is sampled, so each comparator occupies exactly CODE_W*(settleCycles+1)+1 cycles.
- R7: The trim slot n of trimBus (bits n*CODE_W upward) carries stored code n whenever comparator n is not the one being trimmed. rdCode returns stored code rdIdx, or 0 for an index of NUM or more. In idle, the comparator decision has no effect on either.
- R8: After the last fine comparator is stored, calBusy drops, done becomes 1, thConnect returns to 1 and refGenOn to 0. done stays 1 until the next start.
- R9: A start pulse while a run is in progress is ignored: the sequence neither restarts nor skips.
- R10: During a run, the selected comparator's slot on trimBus shows its current trial code rather than its stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run (taken only when idle) |
| settleCycles | input | SETTLE_W | Extra wait cycles after each trim or reference change |
| cmpDecision | input | 1 | Decision of the comparator being trimmed |
| rdIdx | input | IDX_W | Read index into the trim register file |
| rdCode | output | CODE_W | Stored trim code at rdIdx |
| refSel | output | IDX_W | Reference threshold index selected |
| fineStage | output | 1 | 1 while a fine comparator is selected |
| calEn | output | NUM | One-hot enable of comparator trim logic |
| trimBus | output | NUM*CODE_W | Trim codes of all comparators, slot n at n*CODE_W |
| thConnect | output | 1 | Track-and-hold connected to both stages |
| refGenOn | output | 1 | Reference source connected and biased |
| calBusy | output | 1 | Calibration run in progress |
| done | output | 1 | Last run completed |

## Verification
The mode outputs change one edge after start is sampled, and the bench reads them at the next falling edge. A comparator's stored code first becomes visible on its trim slot at the same edge that moves refSel to the next index, or at the edge that drops calBusy for the last entry. The monitor therefore pops the expected code from the scoreboard at the first falling edge where refSel differs, or where calBusy has fallen. It also counts the falling edges spent on each index against CODE_W*(settleCycles+1)+1, and samples the fresh slot for the MSB-only start value in that same half cycle. Runs use settle counts of 0 and 3, so an off-by-one in the settle wait or in the store step shifts every later boundary and appears in the counts.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_STORE  = 2'd2
  } calState_t;

  typedef struct packed {
    logic init;   // load MSB-only trial for a new comparator
    logic step;   // apply sampled decision to the bit under test
    logic store;  // commit trial code for the selected comparator
  } calStrobe_t;
endpackage

// File: rtl/calCtrl.sv
module calCtrl
  import cal_pkg::*;
#(
  parameter int NUM      = 34,
  parameter int CODE_W   = 6,
  parameter int SETTLE_W = 4,
  localparam int IDX_W   = $clog2(NUM),
  localparam int BIT_W   = $clog2(CODE_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic                busy,
  output logic                doneFlag,
  output logic [IDX_W-1:0]    sel,
  output logic [BIT_W-1:0]    bitPos,
  output calStrobe_t          strb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM - 1);
  localparam logic [BIT_W-1:0] TOP_BIT  = BIT_W'(CODE_W - 1);

  calState_t state;
  logic [SETTLE_W-1:0] settleCnt;
  logic settleOver;

  assign settleOver = (settleCnt == settleCycles);
  assign busy       = (state != ST_IDLE);

  always_comb begin
    strb       = '0;
    strb.init  = ((state == ST_IDLE) && start) ||
                 ((state == ST_STORE) && (sel != LAST_IDX));
    strb.step  = (state == ST_SETTLE) && settleOver;
    strb.store = (state == ST_STORE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sel       <= '0;
      bitPos    <= TOP_BIT;
      settleCnt <= '0;
      doneFlag  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_SETTLE;
            sel       <= '0;
            bitPos    <= TOP_BIT;
            settleCnt <= '0;
            doneFlag  <= 1'b0;
          end
        end
        ST_SETTLE: begin
          if (settleOver) begin
            settleCnt <= '0;
            if (bitPos == '0) state <= ST_STORE;
            else              bitPos <= bitPos - BIT_W'(1);
          end else begin
            settleCnt <= settleCnt + SETTLE_W'(1);
          end
        end
        ST_STORE: begin
          if (sel == LAST_IDX) begin
            state    <= ST_IDLE;
            doneFlag <= 1'b1;
          end else begin
            sel    <= sel + IDX_W'(1);
            bitPos <= TOP_BIT;
            state  <= ST_SETTLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: selection only advances by one while a run is active
  p_sel_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (sel != $past(sel))) |-> (sel == $past(sel) + IDX_W'(1)));

  // R8: completion flag only when idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> !busy);

  // R9: start mid-run does not pull selection back to zero
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && (sel != '0)) |=> (sel != '0));
endmodule

// File: rtl/calData.sv
module calData
  import cal_pkg::*;
#(
  parameter int NUM    = 34,
  parameter int CODE_W = 6,
  localparam int IDX_W = $clog2(NUM),
  localparam int BIT_W = $clog2(CODE_W)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  calStrobe_t            strb,
  input  logic                  busy,
  input  logic [IDX_W-1:0]      sel,
  input  logic [BIT_W-1:0]      bitPos,
  input  logic                  cmpDecision,
  input  logic [IDX_W-1:0]      rdIdx,
  output logic [CODE_W-1:0]     rdCode,
  output logic [NUM-1:0]        calEn,
  output logic [NUM*CODE_W-1:0] trimBus
);
  localparam logic [CODE_W-1:0] MSB_ONLY = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] trial, trialNext;
  logic [CODE_W-1:0] codes [NUM];

  always_comb begin
    trialNext = trial;
    if (strb.init) begin
      trialNext = MSB_ONLY;
    end else if (strb.step) begin
      if (cmpDecision) trialNext[bitPos] = 1'b0;
      if (bitPos != '0) trialNext[bitPos - BIT_W'(1)] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trial <= '0;
    else       trial <= trialNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM; i++) codes[i] <= '0;
    end else if (strb.store) begin
      codes[sel] <= trial;
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    logic active;
    assign active = busy && (sel == IDX_W'(g));
    assign calEn[g] = active;
    assign trimBus[g*CODE_W +: CODE_W] = active ? trial : codes[g];
  end

  assign rdCode = (rdIdx < IDX_W'(NUM)) ? codes[rdIdx] : '0;

  // R5: a fresh comparator always begins with the MSB alone
  p_trial_msb_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.init |=> (trial == MSB_ONLY));

  // R6: trial code holds between decision samples
  p_trial_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.init && !strb.step) |=> $stable(trial));

  // R3: one trim enable while busy, none while idle
  p_onehot_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ($countones(calEn) == 1));
  p_idle_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> $onehot0(calEn) && (calEn == '0));
endmodule

// File: rtl/calSequencer.sv
module calSequencer
  import cal_pkg::*;
#(
  parameter int NUM_COARSE = 15,
  parameter int NUM_FINE   = 19,
  parameter int CODE_W     = 6,
  parameter int SETTLE_W   = 4,
  localparam int NUM       = NUM_COARSE + NUM_FINE,
  localparam int IDX_W     = $clog2(NUM),
  localparam int BIT_W     = $clog2(CODE_W)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [SETTLE_W-1:0]   settleCycles,
  input  logic                  cmpDecision,
  input  logic [IDX_W-1:0]      rdIdx,
  output logic [CODE_W-1:0]     rdCode,
  output logic [IDX_W-1:0]      refSel,
  output logic                  fineStage,
  output logic [NUM-1:0]        calEn,
  output logic [NUM*CODE_W-1:0] trimBus,
  output logic                  thConnect,
  output logic                  refGenOn,
  output logic                  calBusy,
  output logic                  done
);
  calStrobe_t strb;
  logic busy;
  logic [IDX_W-1:0] sel;
  logic [BIT_W-1:0] bitPos;

  calCtrl #(.NUM(NUM), .CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .settleCycles(settleCycles),
    .busy(busy), .doneFlag(done), .sel(sel), .bitPos(bitPos), .strb(strb)
  );

  calData #(.NUM(NUM), .CODE_W(CODE_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .sel(sel),
    .bitPos(bitPos), .cmpDecision(cmpDecision), .rdIdx(rdIdx),
    .rdCode(rdCode), .calEn(calEn), .trimBus(trimBus)
  );

  assign refSel    = sel;
  assign fineStage = busy && (sel >= IDX_W'(NUM_COARSE));
  assign calBusy   = busy;
  assign thConnect = !busy;
  assign refGenOn  = busy;

  // R2: input path swapped to the reference source for the whole run
  p_mode_swap_r2: assert property (@(posedge clk) disable iff (!rstN)
    calBusy |-> (!thConnect && refGenOn));
endmodule

// File: tb/tb_calSequencer.sv
`timescale 1ns/1ps
module tb_calSequencer;
  localparam int NC = 15, NF = 19, NUM = NC + NF, CW = 6, SW = 4;
  localparam int IW = $clog2(NUM);

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [SW-1:0] settleCycles = '0;
  logic cmpDecision;
  logic [IW-1:0] rdIdx = '0;
  logic [CW-1:0] rdCode;
  logic [IW-1:0] refSel;
  logic fineStage, thConnect, refGenOn, calBusy, done;
  logic [NUM-1:0] calEn;
  logic [NUM*CW-1:0] trimBus;

  always #2.5 clk = ~clk;

  calSequencer dut (
    .clk(clk), .rstN(rstN), .start(start), .settleCycles(settleCycles),
    .cmpDecision(cmpDecision), .rdIdx(rdIdx), .rdCode(rdCode),
    .refSel(refSel), .fineStage(fineStage), .calEn(calEn), .trimBus(trimBus),
    .thConnect(thConnect), .refGenOn(refGenOn), .calBusy(calBusy), .done(done)
  );

  int total = 0, bad = 0;
  int hidden [NUM];
  int expArr [NUM];
  int expQ [$];
  int perCmp = 0;
  logic ovrEn = 1'b0, ovrVal = 1'b0;

  // comparator model: trips once the trim code reaches its hidden point
  always_comb begin
    cmpDecision = 1'b0;
    for (int i = 0; i < NUM; i++)
      if (calEn[i]) cmpDecision = (int'(trimBus[i*CW +: CW]) >= hidden[i]);
    if (ovrEn) cmpDecision = ovrVal;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int slotOf(input int i);
    return int'(trimBus[i*CW +: CW]);
  endfunction

  // driver: loads hidden points and pushes expected codes to scoreboard
  task automatic loadRun(input int mulv, input int addv);
    for (int i = 0; i < NUM; i++) begin
      hidden[i] = (i * mulv + addv) % 64;
    end
  endtask

  task automatic pushExpected();
    for (int i = 0; i < NUM; i++) begin
      expArr[i] = (hidden[i] == 0) ? 0 : hidden[i] - 1;
      expQ.push_back(expArr[i]);
    end
  endtask

  // monitor
  logic prevBusy = 1'b0;
  int prevSel = 0, cyc = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (calBusy) begin
        chk(calEn == (NUM'(1) << refSel), "R3 calEn", int'(calEn), int'(refSel));
        if (!prevBusy) begin
          chk(refSel == 0, "R4 first index", int'(refSel), 0);
          chk(slotOf(0) == 32, "R5 msb start", slotOf(0), 32);
          cyc = 1; prevSel = int'(refSel);
        end else if (int'(refSel) != prevSel) begin
          int e;
          chk(int'(refSel) == prevSel + 1, "R4 step", int'(refSel), prevSel + 1);
          chk(fineStage == (refSel >= NC), "R4 stage", int'(fineStage), int'(refSel >= NC));
          chk(cyc == perCmp, "R6 cycles", cyc, perCmp);
          e = (expQ.size() > 0) ? expQ.pop_front() : -1;
          chk(slotOf(prevSel) == e, "R5 stored code", slotOf(prevSel), e);
          chk(slotOf(int'(refSel)) == 32, "R10 trial slot", slotOf(int'(refSel)), 32);
          cyc = 1; prevSel = int'(refSel);
        end else begin
          cyc++;
        end
      end else if (prevBusy) begin
        int e;
        chk(cyc == perCmp, "R6 cycles last", cyc, perCmp);
        e = (expQ.size() > 0) ? expQ.pop_front() : -1;
        chk(slotOf(prevSel) == e, "R5 stored last", slotOf(prevSel), e);
      end
      prevBusy = calBusy;
    end
  end

  task automatic waitIdle();
    int n = 0;
    while (calBusy && n < 20000) begin @(negedge clk); n++; end
    chk(!calBusy, "R8 run ends", int'(calBusy), 0);
  endtask

  task automatic checkStored(input string tag);
    for (int i = 0; i < NUM; i++) begin
      rdIdx = IW'(i);
      #0.1;
      chk(int'(rdCode) == expArr[i], tag, int'(rdCode), expArr[i]);
      chk(slotOf(i) == expArr[i], tag, slotOf(i), expArr[i]);
    end
  endtask

  task automatic runCal(input int settle, input bit pokeStart);
    settleCycles = SW'(settle);
    perCmp = CW * (settle + 1) + 1;
    pushExpected();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(calBusy && !thConnect && refGenOn, "R2 mode swap", int'({calBusy, thConnect, refGenOn}), 5);
    chk(!done, "R8 done cleared", int'(done), 0);
    if (pokeStart) begin
      while (refSel != 5) @(negedge clk);
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(calBusy && refSel == 5, "R9 start ignored", int'(refSel), 5);
    end
    waitIdle();
    chk(done && thConnect && !refGenOn, "R8 normal mode", int'({done, thConnect, refGenOn}), 6);
    chk(calEn == '0, "R3 idle enables", int'(calEn), 0);
  endtask

  initial begin
    for (int i = 0; i < NUM; i++) hidden[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(thConnect && !refGenOn && !calBusy && !done, "R1 reset modes",
        int'({thConnect, refGenOn, calBusy, done}), 8);
    chk(calEn == '0, "R1 reset enables", int'(calEn), 0);
    chk(trimBus == '0, "R1 reset trim", int'(trimBus[31:0]), 0);
    rstN = 1'b1;
    @(negedge clk);

    loadRun(37, 11);
    hidden[0] = 0; hidden[1] = 63; hidden[NC] = 1; hidden[NUM-1] = 32;
    runCal(0, 1'b0);
    checkStored("R7 stored run1");

    // R7: idle decisions leave codes untouched; R8 done persists
    ovrEn = 1'b1;
    for (int k = 0; k < 6; k++) begin
      ovrVal = k[0];
      @(negedge clk);
    end
    ovrEn = 1'b0;
    checkStored("R7 idle decision");
    chk(done, "R8 done held", int'(done), 1);
    rdIdx = IW'(NUM + 3); #0.1;
    chk(rdCode == '0, "R7 out of range read", int'(rdCode), 0);

    loadRun(23, 7);
    hidden[2] = 63; hidden[NC+1] = 0;
    runCal(3, 1'b1);
    checkStored("R7 stored run2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule